// File: doc/BRIEF.md
# GPIO Bank Controller with Masked-Write Aliases

This block controls one bank of 32 general-purpose pins, grouped as four 8-bit ports, through a simple 32-bit register bus. For each port, software can set a pin enable, an output enable and an output value. It can read back the synchronized pad state, and it can program a per-pin interrupt detector that senses levels, single edges or both edges. All pending, enabled interrupts of the bank are ORed onto one interrupt line.

Every port register is also visible in an aliased window. A write to the alias carries an 8-bit mask and 8 new bit values in the same word, so software can change some pins of a port in a single write, without a read-modify-write sequence.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The byte address selects a port with bits 3:2 and a register group with bits 6:4: 0 pin enable, 1 output enable, 2 output value, 3 input, 4 interrupt status, 5 interrupt enable, 6 interrupt type, 7 interrupt clear. Address bit log2(MASK_OFS) selects the masked alias. Pin 8*port+bit is driven from bit `bit` of that port's pin enable, output enable and output value registers.
- R2: A plain write loads bits 7:0 into the pin enable, output enable, output value or interrupt enable register. A plain write to the type register loads the polarity field from bits 7:0, the edge field from bits 15:8 and the both-edge field from bits 23:16. Reads return 8-bit registers zero-extended and the type fields at those same positions. The clear register reads as zero. Writes to the input register have no effect.
- R3: A write to the alias treats bits 15:8 as a bit mask and bits 7:0 as values. It changes only the masked bits of the pin enable, output enable, output value, interrupt enable or type polarity field. An alias read returns the plain register value.
- R4: The input register and the interrupt logic see each pad through two flops. A pad value is visible two clock edges after it is sampled.
- R5: The per-pin type code, written {both, edge, polarity}, selects the trigger: 011 rising edge, 010 falling edge, 110 or 111 both edges, 001 high level, 000 low level.
- R6: In edge mode a status bit stays set until cleared. A plain write of 1 to a clear-register bit clears it, and a 0 bit has no effect. An edge detected in the same cycle as its clear leaves the bit set.
- R7: In level mode a status bit equals the trigger condition on the synchronized pin one cycle later, so a clear cannot hold it low while the condition persists.
- R8: A masked-alias write to the status register sets or clears edge-mode status bits under the mask. Plain writes to the status register and alias writes to the clear register have no effect.
- R9: irq_o is high exactly when some pin has both its status bit and its enable bit set.
- R10: After reset all configuration, enable and type registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the current address |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pad_in_i | input | 32 | Raw pad input levels |
| pin_en_o | output | 32 | Per-pin enable |
| pad_oe_o | output | 32 | Per-pin output enable |
| pad_out_o | output | 32 | Per-pin output value |
| irq_o | output | 1 | Aggregated bank interrupt |

## Verification
On every cycle, the assertions check four things: the two-flop input latency, that level-mode status follows the synchronized pin, that sticky edge status never drops without a clear, status or type write, and that a masked write leaves unmasked pin enables untouched. They also check that the interrupt line is quiet when all enables are zero. The bench scenarios cover what needs a sequence of register operations. These are the trigger codes across each edge kind, the edge that lands in the same cycle as its own clear, clears that cannot hold a level bit low, and alias writes to status. Randomly mixed writes and pad changes are compared against a transaction-level model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PORT_W  = 8;
  localparam int NPORTS  = 4;
  localparam int NPIN    = PORT_W * NPORTS;
  localparam int PSEL_W  = $clog2(NPORTS);
  localparam int GRP_LSB = 2 + PSEL_W;

  typedef enum logic [2:0] {
    GRP_CFG  = 3'd0,
    GRP_OE   = 3'd1,
    GRP_OUT  = 3'd2,
    GRP_IN   = 3'd3,
    GRP_STA  = 3'd4,
    GRP_EN   = 3'd5,
    GRP_TYPE = 3'd6,
    GRP_CLR  = 3'd7
  } grp_e;

  function automatic logic [PORT_W-1:0] mask_upd(input logic [PORT_W-1:0] old_v,
                                                 input logic [PORT_W-1:0] msk,
                                                 input logic [PORT_W-1:0] val);
    return (old_v & ~msk) | (val & msk);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_bank_pkg::*;
#(
  parameter int PW = PORT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          masked_i,
  input  grp_e          grp_i,
  input  logic [3*PW-1:0] wdata_i,
  input  logic [PW-1:0] pin_i,
  output logic [PW-1:0] cfg_o,
  output logic [PW-1:0] oe_o,
  output logic [PW-1:0] out_o,
  output logic [PW-1:0] sta_o,
  output logic [PW-1:0] en_o,
  output logic [PW-1:0] pol_o,
  output logic [PW-1:0] edge_o,
  output logic [PW-1:0] both_o
);
  logic [PW-1:0] msk, val, prev_q;
  logic [PW-1:0] rise, fall, trig, lvl_hit;
  logic [PW-1:0] clr_vec, sclr, sset, sticky, sta_d;

  assign msk = masked_i ? wdata_i[2*PW-1:PW] : '1;
  assign val = wdata_i[PW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '0;
      oe_o   <= '0;
      out_o  <= '0;
      en_o   <= '0;
      pol_o  <= '0;
      edge_o <= '0;
      both_o <= '0;
    end else if (wr_i) begin
      unique case (grp_i)
        GRP_CFG: cfg_o <= mask_upd(cfg_o, msk, val);
        GRP_OE:  oe_o  <= mask_upd(oe_o, msk, val);
        GRP_OUT: out_o <= mask_upd(out_o, msk, val);
        GRP_EN:  en_o  <= mask_upd(en_o, msk, val);
        GRP_TYPE: begin
          pol_o <= mask_upd(pol_o, msk, val);
          if (!masked_i) begin
            edge_o <= wdata_i[2*PW-1:PW];
            both_o <= wdata_i[3*PW-1:2*PW];
          end
        end
        default: ;
      endcase
    end
  end

  // trigger detection on synchronized pins
  always_comb begin
    rise    = pin_i & ~prev_q;
    fall    = ~pin_i & prev_q;
    trig    = (both_o & (rise | fall)) | (~both_o & pol_o & rise) | (~both_o & ~pol_o & fall);
    lvl_hit = ~(pin_i ^ pol_o);
    clr_vec = (wr_i && !masked_i && grp_i == GRP_CLR) ? val : '0;
    sclr    = (wr_i && masked_i && grp_i == GRP_STA) ? (msk & ~val) : '0;
    sset    = (wr_i && masked_i && grp_i == GRP_STA) ? (msk & val) : '0;
    // new edge wins over a clear in the same cycle
    sticky  = (sta_o & ~clr_vec & ~sclr) | sset | trig;
    sta_d   = (edge_o & sticky) | (~edge_o & lvl_hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      sta_o  <= '0;
    end else begin
      prev_q <= pin_i;
      sta_o  <= sta_d;
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] MASK_OFS = 32'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NPIN-1:0]   pad_in_i,
  output logic [NPIN-1:0]   pin_en_o,
  output logic [NPIN-1:0]   pad_oe_o,
  output logic [NPIN-1:0]   pad_out_o,
  output logic              irq_o
);
  localparam int PW       = PORT_W;
  localparam int MASK_BIT = $clog2(MASK_OFS);

  grp_e              grp;
  logic [PSEL_W-1:0] psel;
  logic              masked;
  logic [NPIN-1:0]   sync_in, sta_all, en_all, pol_all, edge_all, both_all;
  logic              unused_bits;

  assign grp         = grp_e'(addr_i[GRP_LSB +: 3]);
  assign psel        = addr_i[2 +: PSEL_W];
  assign masked      = addr_i[MASK_BIT];
  assign unused_bits = ^{addr_i, wdata_i[31:3*PW]};

  gpio_sync #(.W(NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (sync_in)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    gpio_port #(.PW(PW)) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i && psel == PSEL_W'(p)),
      .masked_i(masked),
      .grp_i   (grp),
      .wdata_i (wdata_i[3*PW-1:0]),
      .pin_i   (sync_in[p*PW +: PW]),
      .cfg_o   (pin_en_o[p*PW +: PW]),
      .oe_o    (pad_oe_o[p*PW +: PW]),
      .out_o   (pad_out_o[p*PW +: PW]),
      .sta_o   (sta_all[p*PW +: PW]),
      .en_o    (en_all[p*PW +: PW]),
      .pol_o   (pol_all[p*PW +: PW]),
      .edge_o  (edge_all[p*PW +: PW]),
      .both_o  (both_all[p*PW +: PW])
    );
  end

  always_comb begin
    rdata_o = '0;
    unique case (grp)
      GRP_CFG:  rdata_o[PW-1:0] = pin_en_o[psel*PW +: PW];
      GRP_OE:   rdata_o[PW-1:0] = pad_oe_o[psel*PW +: PW];
      GRP_OUT:  rdata_o[PW-1:0] = pad_out_o[psel*PW +: PW];
      GRP_IN:   rdata_o[PW-1:0] = sync_in[psel*PW +: PW];
      GRP_STA:  rdata_o[PW-1:0] = sta_all[psel*PW +: PW];
      GRP_EN:   rdata_o[PW-1:0] = en_all[psel*PW +: PW];
      GRP_TYPE: rdata_o[3*PW-1:0] = {both_all[psel*PW +: PW], edge_all[psel*PW +: PW],
                                     pol_all[psel*PW +: PW]};
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = |(sta_all & en_all);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] MASK_OFS = 32'h80
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [NPIN-1:0]   pad_in_i,
  input logic [NPIN-1:0]   pin_en_o,
  input logic              irq_o,
  input logic [NPIN-1:0]   sync_in,
  input logic [NPIN-1:0]   sta_all,
  input logic [NPIN-1:0]   en_all,
  input logic [NPIN-1:0]   pol_all,
  input logic [NPIN-1:0]   edge_all
);
  localparam int MASK_BIT = $clog2(MASK_OFS);

  logic [1:0]      age;
  logic [2:0]      grp;
  logic            touch_sta, cfg_mwr;
  logic [NPIN-1:0] cfg_mask;
  logic            unused_chk;

  assign grp        = addr_i[GRP_LSB +: 3];
  assign touch_sta  = wr_en_i && (grp == 3'd4 || grp == 3'd6 || grp == 3'd7);
  assign cfg_mwr    = wr_en_i && addr_i[MASK_BIT] && grp == 3'd0;
  assign cfg_mask   = NPIN'(wdata_i[15:8]) << (PORT_W * int'(addr_i[2 +: PSEL_W]));
  assign unused_chk = ^{addr_i, wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_sync_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age == 2'd3 |-> sync_in == $past(pad_in_i, 2));

  assert_edge_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !touch_sta |=> ((sta_all & $past(sta_all & edge_all)) == $past(sta_all & edge_all)));

  assert_level_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age != 2'd0 |-> ((sta_all & ~$past(edge_all)) ==
                     (~($past(sync_in) ^ $past(pol_all)) & ~$past(edge_all))));

  assert_masked_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_mwr |=> (((pin_en_o ^ $past(pin_en_o)) & ~$past(cfg_mask)) == '0));

  assert_irq_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_all == '0 |-> !irq_o);
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .pad_in_i(pad_in_i),
  .pin_en_o(pin_en_o),
  .irq_o   (irq_o),
  .sync_in (sync_in),
  .sta_all (sta_all),
  .en_all  (en_all),
  .pol_all (pol_all),
  .edge_all(edge_all)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam logic [31:0] MASK_OFS = 32'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad = '0;
  logic [31:0] pin_en, pad_oe, pad_out;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] m_cfg[4], m_oe[4], m_out[4], m_en[4], m_pol[4], m_edge[4], m_both[4], m_sta[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS)) u_gpio_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad), .pin_en_o(pin_en), .pad_oe_o(pad_oe),
    .pad_out_o(pad_out), .irq_o(irq)
  );

  function automatic logic [7:0] upd(logic [7:0] o, logic [7:0] m, logic [7:0] v);
    return (o & ~m) | (v & m);
  endfunction

  function automatic logic [ADDR_W-1:0] mk_addr(int grp, int port, bit masked);
    return ADDR_W'((grp << 4) | (port << 2)) | (masked ? ADDR_W'(MASK_OFS) : '0);
  endfunction

  function automatic logic [31:0] exp_rd(int grp, int p);
    case (grp)
      0: return {24'h0, m_cfg[p]};
      1: return {24'h0, m_oe[p]};
      2: return {24'h0, m_out[p]};
      3: return {24'h0, pad[p*8 +: 8]};
      4: return {24'h0, m_sta[p]};
      5: return {24'h0, m_en[p]};
      6: return {8'h0, m_both[p], m_edge[p], m_pol[p]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int p = 0; p < 4; p++) r |= |(m_sta[p] & m_en[p]);
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic recompute_level();
    for (int p = 0; p < 4; p++)
      m_sta[p] = (m_edge[p] & m_sta[p]) | (~m_edge[p] & ~(pad[p*8 +: 8] ^ m_pol[p]));
  endtask

  task automatic model_write(int grp, int p, bit masked, logic [31:0] d);
    logic [7:0] m, v;
    m = masked ? d[15:8] : 8'hFF;
    v = d[7:0];
    case (grp)
      0: m_cfg[p] = upd(m_cfg[p], m, v);
      1: m_oe[p]  = upd(m_oe[p], m, v);
      2: m_out[p] = upd(m_out[p], m, v);
      4: if (masked) m_sta[p] = upd(m_sta[p], m & m_edge[p], v);
      5: m_en[p]  = upd(m_en[p], m, v);
      6: begin
        m_pol[p] = upd(m_pol[p], m, v);
        if (!masked) begin
          m_edge[p] = d[15:8];
          m_both[p] = d[23:16];
        end
      end
      7: if (!masked) m_sta[p] = m_sta[p] & ~(v & m_edge[p]);
      default: ;
    endcase
  endtask

  // called at a negedge; returns at the negedge after the commit
  task automatic bus_wr(int grp, int p, bit masked, logic [31:0] d);
    addr  = mk_addr(grp, p, masked);
    wdata = d;
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_wr(int grp, int p, bit masked, logic [31:0] d);
    bus_wr(grp, p, masked, d);
    model_write(grp, p, masked, d);
    @(negedge clk);
    recompute_level();
  endtask

  task automatic rd(int grp, int p, bit masked, output logic [31:0] d);
    addr = mk_addr(grp, p, masked);
    #1;
    d = rdata;
  endtask

  task automatic set_pad(logic [31:0] nv);
    for (int p = 0; p < 4; p++) begin
      logic [7:0] o, n, r, f, t;
      o = pad[p*8 +: 8];
      n = nv[p*8 +: 8];
      r = n & ~o;
      f = ~n & o;
      t = (m_both[p] & (r | f)) | (~m_both[p] & m_pol[p] & r) | (~m_both[p] & ~m_pol[p] & f);
      m_sta[p] |= t & m_edge[p];
    end
    pad = nv;
    repeat (4) @(negedge clk);
    recompute_level();
  endtask

  task automatic chk_rd(string tag, int grp, int p, bit masked);
    logic [31:0] d;
    rd(grp, p, masked, d);
    check(tag, d, exp_rd(grp, p));
  endtask

  task automatic chk_outs(string tag);
    logic [31:0] ec, eo, ev;
    for (int p = 0; p < 4; p++) begin
      ec[p*8 +: 8] = m_cfg[p];
      eo[p*8 +: 8] = m_oe[p];
      ev[p*8 +: 8] = m_out[p];
    end
    check({tag, " pin_en"}, pin_en, ec);
    check({tag, " pad_oe"}, pad_oe, eo);
    check({tag, " pad_out"}, pad_out, ev);
    check({"R9 irq ", tag}, {31'h0, irq}, {31'h0, exp_irq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < 4; p++) begin
      m_cfg[p] = 0; m_oe[p] = 0; m_out[p] = 0; m_en[p] = 0;
      m_pol[p] = 0; m_edge[p] = 0; m_both[p] = 0; m_sta[p] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    recompute_level();

    // R10 reset state
    for (int p = 0; p < 4; p++) begin
      rd(0, p, 0, d); check("R10 cfg", d, 0);
      rd(6, p, 0, d); check("R10 type", d, 0);
      rd(5, p, 0, d); check("R10 en", d, 0);
    end
    chk_outs("R10");

    // R1/R2 plain writes and pin mapping
    do_wr(0, 1, 0, 32'hFFFF_FFA5);
    rd(0, 1, 0, d); check("R2 cfg plain", d, 32'h0000_00A5);
    check("R1 pin map", pin_en, 32'h0000_A500);
    do_wr(3, 2, 0, 32'h0000_00FF);
    rd(3, 2, 0, d); check("R2 input write ignored", d, 32'h0);

    // R3 masked write
    do_wr(0, 1, 1, 32'h0000_F00F);
    rd(0, 1, 0, d); check("R3 masked cfg", d, 32'h05);
    rd(0, 1, 1, d); check("R3 alias read", d, 32'h05);
    do_wr(2, 3, 1, 32'h0000_0381);
    check("R3 masked out", pad_out, 32'h0100_0000);

    // R5 type codes on port 0: pin0 rise, pin1 fall, pin2 both, pin3 high, rest low
    do_wr(6, 0, 0, 32'h0004_0709);
    do_wr(7, 0, 0, 32'h0000_00FF);
    rd(4, 0, 0, d); check("R5 status after clear", d, 32'hF0);
    set_pad(32'h0000_000F);
    rd(4, 0, 0, d); check("R5 rise/both/high", d, 32'hFD);
    rd(3, 0, 0, d); check("R4 input sync", d, 32'h0F);
    do_wr(7, 0, 0, 32'h0000_0007);
    set_pad(32'h0000_0000);
    rd(4, 0, 0, d); check("R5 fall/both/low", d, 32'hF6);

    // R6 zero bits of clear have no effect
    do_wr(7, 0, 0, 32'h0);
    rd(4, 0, 0, d); check("R6 zero clear", d, 32'hF6);
    // R7 clear cannot hold a level bit low
    do_wr(7, 0, 0, 32'h10);
    rd(4, 0, 0, d); check("R7 level persists", d, 32'hF6);
    // R8 masked status write and ignored plain write
    do_wr(4, 0, 1, 32'h0000_0701);
    rd(4, 0, 0, d); check("R8 masked status", d, 32'hF1);
    do_wr(4, 0, 0, 32'h0000_0000);
    rd(4, 0, 0, d); check("R8 plain status ignored", d, 32'hF1);
    do_wr(7, 0, 1, 32'h0000_FFFF);
    rd(4, 0, 0, d); check("R8 alias clear ignored", d, 32'hF1);

    // R6 edge and clear in the same cycle
    do_wr(7, 0, 0, 32'h01);
    rd(4, 0, 0, d); check("R6 cleared", d, 32'hF0);
    pad = 32'h0000_0001;
    @(negedge clk);
    @(negedge clk);
    bus_wr(7, 0, 0, 32'h01);
    m_sta[0] |= 8'h01;
    @(negedge clk);
    recompute_level();
    rd(4, 0, 0, d); check("R6 edge beats clear", d, 32'hF1);

    // R9 interrupt aggregation
    do_wr(5, 0, 0, 32'h01);
    check("R9 irq set", {31'h0, irq}, 32'h1);
    do_wr(7, 0, 0, 32'h01);
    check("R9 irq cleared", {31'h0, irq}, 32'h0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op, grp, p;
      bit mk;
      op = int'($urandom_range(0, 3));
      if (op <= 1) begin
        grp = int'($urandom_range(0, 7));
        p = int'($urandom_range(0, 3));
        mk = 1'($urandom_range(0, 1));
        do_wr(grp, p, mk, $urandom);
      end else if (op == 2) begin
        set_pad($urandom);
      end else begin
        @(negedge clk);
      end
      grp = int'($urandom_range(0, 7));
      p = int'($urandom_range(0, 3));
      mk = 1'($urandom_range(0, 1));
      chk_rd("R1 random read", grp, p, mk);
      chk_outs("R1 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule